// File: doc/BRIEF.md
# Display Serial Command/Data Transmitter

This block serializes a stream of bytes toward a display panel over a write-only serial link. Each input byte arrives on a valid/ready port. It carries a tag that marks it as a command or as data, plus an end-of-transfer flag. The block drives a serial clock, a serial data line, an active-low chip select and a separate command/data pin.

Three framings are chosen at run time. Their settings are sampled once, when a byte is accepted:
- A 3-wire framing, where the tag travels in-band as a leading ninth bit.
- A 4-wire framing of 8 clocks per byte, where the tag sits on the command/data pin.
- A 4-wire framing of 16-bit blocks, where the byte is padded with eight leading stuffing zeros.

The serial clock rate comes from a programmable half-period divider. Chip select stays asserted across consecutive bytes until a byte flagged as the end of the transfer has been sent. After that byte the line is deselected for one full serial clock period.

Top module: `dbi_serial_tx`

## Requirements
- R1: While reset is asserted, and right after it, cs_n is 1, sck is 0, dout is 0 and in_ready is 1.
- R2: With cfg_mode equal to 1 (3-wire), each accepted byte produces exactly 9 rising sck edges. The first bit is the tag (1 = data, 0 = command), followed by byte bits 7 down to 0.
- R3: With 4-wire framing and 8-bit width, each byte produces exactly 8 rising sck edges carrying bits 7 down to 0. The dc pin equals the tag (1 = data) for the whole word and does not change until the next byte is accepted.
- R4: With 4-wire framing and cfg_width equal to 16, each byte produces exactly 16 rising sck edges: eight 0 bits, then byte bits 7 down to 0. The dc pin holds the tag throughout.
- R5: Any cfg_mode value other than 1 selects 4-wire framing. Any cfg_width value other than 16 selects 8-bit width. cfg_width has no effect in 3-wire mode. All three configuration inputs are sampled only when a byte is accepted.
- R6: sck idles low. Each sck half-period lasts cfg_div+1 clock cycles, using the cfg_div value sampled at acceptance. dout changes only while sck is low.
- R7: in_ready is 1 only when the block is idle or has finished the final bit of a word not flagged last. A byte is accepted on a clock edge where in_valid and in_ready are both 1, and the new word starts on the cycle after.
- R8: cs_n falls on the cycle after a byte is accepted. It stays 0 across following words, including gaps, as long as no accepted byte carried in_last.
- R9: After a byte flagged last, cs_n stays 0 for one more sck half-period after the final falling sck edge. It then stays 1 for two half-periods with in_ready 0, and then in_ready returns to 1.
- R10: In 3-wire mode the dc pin is driven 0. dout is 0 whenever cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Framing select: 1 = 3-wire, other = 4-wire |
| cfg_width | input | 5 | 4-wire word width: 16 = padded block, other = 8 |
| cfg_div | input | DIV_W | sck half-period length minus one, in clock cycles |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | Tag: 1 = data, 0 = command |
| in_last | input | 1 | Byte ends the transfer |
| sck | output | 1 | Serial clock, idle low |
| dout | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low chip select |
| dc | output | 1 | Command/data pin for 4-wire framing |

## Verification
Two events can coincide in one cycle. One is the end of a word not flagged last, which raises in_ready for its first cycle. The other is acceptance of the next byte, which reloads the shifter, the divider and the latched configuration. The bench provokes this by keeping in_valid asserted through consecutive sends, so the next byte is taken in the very first ready cycle. It also changes the configuration in the middle of a word and repeats the test with delayed offers. A behavioural cycle model predicts sck, dout, cs_n, dc and in_ready on every cycle. A separate capture of the bits at each rising sck edge checks each whole frame against the framing rules.

// File: rtl/dbi_tx_pkg.sv
package dbi_tx_pkg;

  localparam int unsigned FRAME_MAX = 16;
  localparam int unsigned LEN_W     = $clog2(FRAME_MAX + 1);

  localparam logic [1:0] MODE_IN_BAND = 2'd1;
  localparam logic [4:0] WIDTH_BLOCK  = 5'd16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_TAIL,
    ST_DESA,
    ST_DESB
  } tx_state_e;

  // number of serial clocks one byte occupies for a given setting
  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] mode,
                                                 input logic [4:0] width);
    if (mode == MODE_IN_BAND)     return LEN_W'(9);
    else if (width == WIDTH_BLOCK) return LEN_W'(16);
    else                           return LEN_W'(8);
  endfunction

  // frame left-aligned in a FRAME_MAX-bit register, first bit at the top
  function automatic logic [FRAME_MAX-1:0] frame_word(input logic [7:0] b,
                                                      input logic       tag,
                                                      input logic [1:0] mode,
                                                      input logic [4:0] width);
    if (mode == MODE_IN_BAND)      return {tag, b, 7'b0};
    else if (width == WIDTH_BLOCK) return {8'h00, b};
    else                           return {b, 8'h00};
  endfunction

  function automatic logic is_out_of_band(input logic [1:0] mode);
    return mode != MODE_IN_BAND;
  endfunction

endpackage

// File: rtl/dbi_tx_divider.sv
module dbi_tx_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart || tick) cnt <= reload;
    else                    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dbi_tx_shifter.sv
module dbi_tx_shifter
  import dbi_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] word_in,
  input  logic [LEN_W-1:0]     len_in,
  input  logic                 shift,
  output logic                 msb,
  output logic                 final_bit
);
  logic [FRAME_MAX-1:0] sreg;
  logic [LEN_W-1:0]     left;

  assign msb       = sreg[FRAME_MAX-1];
  assign final_bit = (left == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= word_in;
      left <= len_in;
    end else if (shift) begin
      sreg <= {sreg[FRAME_MAX-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (left > LEN_W'(1))); // R2
  AST_LOAD_XOR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R7
endmodule

// File: rtl/dbi_tx_fsm.sv
module dbi_tx_fsm
  import dbi_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic tick,
  input  logic final_bit,
  output logic accept,
  output logic shift,
  output logic ready,
  output logic sck,
  output logic cs_n,
  output logic drive_en
);
  tx_state_e state;
  logic      last_q;

  assign ready    = (state == ST_IDLE) || (state == ST_HOLD);
  assign accept   = ready && in_valid;
  assign shift    = (state == ST_HIGH) && tick && !final_bit;
  assign sck      = (state == ST_HIGH);
  assign cs_n     = (state == ST_IDLE) || (state == ST_DESA) || (state == ST_DESB);
  assign drive_en = !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      last_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_HOLD: if (accept) begin
          state  <= ST_LOW;
          last_q <= in_last;
        end
        ST_LOW:  if (tick) state <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (!final_bit)  state <= ST_LOW;
          else if (last_q) state <= ST_TAIL;
          else             state <= ST_HOLD;
        end
        ST_TAIL: if (tick) state <= ST_DESA;
        ST_DESA: if (tick) state <= ST_DESB;
        ST_DESB: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DESELECT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R9
  AST_DESELECT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sck)); // R9
endmodule

// File: rtl/dbi_serial_tx.sv
module dbi_serial_tx
  import dbi_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [4:0]       cfg_width,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  input  logic             in_is_data,
  input  logic             in_last,
  output logic             sck,
  output logic             dout,
  output logic             cs_n,
  output logic             dc
);
  localparam int unsigned HL_W = DIV_W + 1;

  logic             accept, shift, tick, final_bit, msb, drive_en;
  logic             oob_q, tag_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] reload;
  logic [HL_W-1:0]  hi_len;

  assign reload = accept ? cfg_div : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oob_q <= 1'b1;
      tag_q <= 1'b0;
      div_q <= '0;
    end else if (accept) begin
      oob_q <= is_out_of_band(cfg_mode);
      tag_q <= in_is_data;
      div_q <= cfg_div;
    end
  end

  dbi_tx_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .reload  (reload),
    .tick    (tick)
  );

  dbi_tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .word_in   (frame_word(in_byte, in_is_data, cfg_mode, cfg_width)),
    .len_in    (frame_len(cfg_mode, cfg_width)),
    .shift     (shift),
    .msb       (msb),
    .final_bit (final_bit)
  );

  dbi_tx_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .tick      (tick),
    .final_bit (final_bit),
    .accept    (accept),
    .shift     (shift),
    .ready     (in_ready),
    .sck       (sck),
    .cs_n      (cs_n),
    .drive_en  (drive_en)
  );

  assign dout = drive_en & msb;
  assign dc   = oob_q & tag_q;

  // length of the current high phase, for the half-period check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= '0;
    else if (sck) hi_len <= hi_len + 1'b1;
    else          hi_len <= '0;
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n); // R8
  AST_DOUT_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(dout)); // R6
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_len == ({1'b0, div_q} + 1'b1))); // R6
  AST_READY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sck); // R7
  AST_DC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (oob_q && !cs_n && !$past(accept)) |-> $stable(dc)); // R3
  AST_IDLE_DOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout); // R10
endmodule

// File: tb/sim_dbi_serial_tx.sv
module sim_dbi_serial_tx;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_mode = 2'd1;
  logic [4:0]       cfg_width = 5'd8;
  logic [DIV_W-1:0] cfg_div = '0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic             in_is_data = 1'b0;
  logic             in_last = 1'b0;
  logic             in_ready, sck, dout, cs_n, dc;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbi_serial_tx #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .cfg_div(cfg_div), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .sck(sck), .dout(dout), .cs_n(cs_n), .dc(dc));

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // each entry: {sck, cs_n, dout, ready} for one clock cycle
  logic [3:0] plan_q[$];
  logic [3:0] cur = 4'b0101;
  bit         m_hold = 1'b0;
  bit         m_lastbit = 1'b0;
  bit         m_dc = 1'b0;
  // expected frames for the edge capture
  bit         frm_bits[$][$];
  string      frm_req[$];

  task automatic build_word();
    bit bits[$];
    int half;
    bit in_band;
    string req;
    in_band = (cfg_mode == 2'd1);
    half = int'(cfg_div) + 1;
    if (in_band) begin
      bits.push_back(in_is_data);
      for (int i = 7; i >= 0; i--) bits.push_back(in_byte[i]);
      req = (cfg_width != 5'd8) ? "R5" : "R2";
    end else begin
      if (cfg_width == 5'd16)
        for (int i = 0; i < 8; i++) bits.push_back(1'b0);
      for (int i = 7; i >= 0; i--) bits.push_back(in_byte[i]);
      if (cfg_mode != 2'd2 || (cfg_width != 5'd8 && cfg_width != 5'd16)) req = "R5";
      else if (cfg_width == 5'd16) req = "R4";
      else req = "R3";
    end
    frm_bits.push_back(bits);
    frm_req.push_back(req);
    foreach (bits[k]) begin
      for (int c = 0; c < half; c++) plan_q.push_back({1'b0, 1'b0, bits[k], 1'b0});
      for (int c = 0; c < half; c++) plan_q.push_back({1'b1, 1'b0, bits[k], 1'b0});
    end
    m_lastbit = bits[bits.size()-1];
    m_dc = in_band ? 1'b0 : in_is_data;
    m_hold = !in_last;
    if (in_last) begin
      for (int c = 0; c < half; c++) plan_q.push_back({1'b0, 1'b0, m_lastbit, 1'b0});
      for (int c = 0; c < 2*half; c++) plan_q.push_back(4'b0100);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      plan_q.delete();
      m_hold = 1'b0; m_lastbit = 1'b0; m_dc = 1'b0;
      cur = 4'b0101;
    end else begin
      if (cur[0] && in_valid) build_word();
      if (plan_q.size() > 0) cur = plan_q.pop_front();
      else cur = {1'b0, !m_hold, m_hold ? m_lastbit : 1'b0, 1'b1};
    end
  end

  // ---------------- per-cycle comparison and frame capture ----------------
  bit prev_sck = 1'b0;
  bit cap[$];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R6", "sck", int'(sck), int'(cur[3]));
      check("R8/R9", "cs_n", int'(cs_n), int'(cur[2]));
      check("R10/R2/R3/R4", "dout", int'(dout), int'(cur[1]));
      check("R7", "in_ready", int'(in_ready), int'(cur[0]));
      check("R3/R4/R10", "dc", int'(dc), int'(m_dc));
      if (sck && !prev_sck) begin
        cap.push_back(dout);
        if (frm_bits.size() > 0 && cap.size() == frm_bits[0].size()) begin
          for (int k = 0; k < cap.size(); k++)
            check(frm_req[0], "frame bit", int'(cap[k]), int'(frm_bits[0][k]));
          cap.delete();
          void'(frm_bits.pop_front());
          void'(frm_req.pop_front());
        end else if (frm_bits.size() == 0) begin
          check("R7", "unexpected sck edge", 1, 0);
          cap.delete();
        end
      end
      prev_sck = sck;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] b, input logic tag, input logic last);
    bit r;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_data = tag; in_last = last;
    forever begin
      r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic go_quiet(input int cycles);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (in_ready && cs_n && plan_q.size() == 0) break;
    end
    check("R9", "returned to idle", int'(in_ready && cs_n), 1);
  endtask

  initial begin
    #1;
    // R1: reset values while reset is asserted
    check("R1", "cs_n in reset", int'(cs_n), 1);
    check("R1", "sck in reset", int'(sck), 0);
    check("R1", "dout in reset", int'(dout), 0);
    check("R1", "in_ready in reset", int'(in_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: in-band tag, fastest clock
    cfg_mode = 2'd1; cfg_width = 5'd8; cfg_div = 8'd0;
    send(8'h2A, 1'b0, 1'b0);
    send(8'hC5, 1'b1, 1'b1);
    drain();

    // R3: back-to-back words, accept coincides with first ready cycle
    cfg_mode = 2'd2; cfg_width = 5'd8; cfg_div = 8'd2;
    send(8'hA5, 1'b0, 1'b0);
    send(8'h5A, 1'b1, 1'b0);
    send(8'hFF, 1'b1, 1'b1);
    drain();

    // R8: gap with chip select held low between words
    cfg_div = 8'd1;
    send(8'h81, 1'b0, 1'b0);
    go_quiet(30);
    send(8'h7E, 1'b1, 1'b1);
    drain();

    // R4: padded 16-bit blocks
    cfg_mode = 2'd2; cfg_width = 5'd16; cfg_div = 8'd1;
    send(8'h3C, 1'b0, 1'b1);
    drain();
    send(8'h81, 1'b1, 1'b0);
    send(8'h01, 1'b0, 1'b1);
    drain();

    // R5: odd mode / width codes, width ignored in 3-wire
    cfg_mode = 2'd3; cfg_width = 5'd12; cfg_div = 8'd0;
    send(8'h96, 1'b1, 1'b1);
    drain();
    cfg_mode = 2'd1; cfg_width = 5'd16; cfg_div = 8'd3;
    send(8'h69, 1'b1, 1'b1);
    drain();

    // R5/R6: configuration changed in the middle of a word has no effect
    cfg_mode = 2'd2; cfg_width = 5'd8; cfg_div = 8'd4;
    send(8'hB3, 1'b1, 1'b0);
    @(negedge clk);
    cfg_mode = 2'd1; cfg_width = 5'd16; cfg_div = 8'd0;
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    send(8'h4D, 1'b0, 1'b1);
    drain();

    check("R2/R3/R4", "all frames captured", frm_bits.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule